// File: doc/BRIEF.md
# Exception Entry and Mode Controller

This block sits beside the control path of a 32-bit RISC core and handles the status-register half of taking an exception. Seven request lines come in: reset, data abort, fast interrupt, normal interrupt, prefetch abort, software interrupt and undefined instruction. The core also supplies its current status word and current PC. In every cycle where the result slot is free, the block masks the two interrupt lines against the I and F bits of the status word and picks the winner by fixed priority. It then registers a complete entry record: the exception kind, the new mode, the new status word, the saved copy of the old status word, the link value and the vector address. At the same edge, the old status word is written into the saved-status slot that belongs to the new mode.

The entry record leaves on a valid/ready stream. `ent_valid` rises one clock after the request is sampled. While `ent_valid` is high and `ent_ready` is low, every record field holds still and no new arbitration takes place, so requests seen during that time are neither lost nor merged. The sources must hold them. A record is consumed on any clock where both signals are high, and the next record, if a request is present, is formed at that same edge.

A separate return path restores the status word. A one-cycle `ret_req` causes `ret_valid` to be high for one cycle on the next clock. At that point `ret_psr` carries the saved copy that belongs to the mode in the current status word.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Winner priority is reset, then data abort, fast interrupt, normal interrupt, prefetch abort, software interrupt, and undefined instruction last. A software interrupt beats a simultaneous undefined instruction. `ent_kind` codes the winner as 0 reset, 1 data abort, 2 fast interrupt, 3 normal interrupt, 4 prefetch abort, 5 software interrupt, 6 undefined.
- R2: The new mode `ent_mode` is 10011 for reset and software interrupt, 10111 for either abort, 10001 for fast interrupt, 10010 for normal interrupt and 11011 for undefined. It equals bits 4:0 of `ent_psr`.
- R3: `ent_vector` is the base parameter plus an offset: 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 normal interrupt, 0x1C fast interrupt.
- R4: `ent_spsr` is the status word that was present at the sampling edge. It is also stored in the saved-status slot of the new mode at that edge.
- R5: `ent_psr` keeps bits 31:8 of the old status word. It forces I (bit 7) to 1 on every entry, forces F (bit 6) to 1 on fast interrupt and reset, clears T (bit 5), and places the new mode in bits 4:0.
- R6: A normal interrupt request is ignored while bit 7 of the status word is 1. A fast interrupt request is ignored while bit 6 is 1. A lower-priority request then wins, or no record is produced.
- R7: If the slot is free (`ent_valid` low or `ent_ready` high), the record is formed one clock after the requests are sampled, and `ent_valid` falls if there is no request. While `ent_valid` is high and `ent_ready` is low, all record outputs hold.
- R8: `ent_link` equals the current PC plus 4, taken at the same edge as `ent_spsr`.
- R9: One clock after `ret_req`, `ret_valid` is 1 for that cycle. `ret_psr` is then the slot of the mode in bits 4:0 of the status word at the request, read before any write at that edge. For modes without a slot (10000, 11111 or unlisted codes), it is the status word unchanged.
- R10: Reset clears `ent_valid`, `ret_valid` and all five saved-status slots to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_reset | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_swi | input | 1 | Software interrupt request |
| req_undef | input | 1 | Undefined instruction request |
| cur_psr | input | 32 | Current status word |
| cur_pc | input | ADDR_W | Current PC |
| ent_ready | input | 1 | Consumer accepts the entry record |
| ent_valid | output | 1 | Entry record valid |
| ent_kind | output | 3 | Winning exception code |
| ent_mode | output | 5 | New mode code |
| ent_psr | output | 32 | Status word after entry |
| ent_spsr | output | 32 | Saved copy of the status word |
| ent_link | output | ADDR_W | Return link value |
| ent_vector | output | ADDR_W | Handler vector address |
| ret_req | input | 1 | Return strobe |
| ret_valid | output | 1 | Restored status word valid |
| ret_psr | output | 32 | Restored status word |

## Verification
The hardest case to reach is several overlapping events on one record. A masked interrupt competes with a lower-priority source while the stream is stalled, and a return reads the very slot that an entry writes at the same edge. Directed sequences set I or F, hold `ent_ready` low across request and status changes, and issue `ret_req` on an entry edge. A long random run then mixes sparse requests, random status words drawn from all mode codes, random ready, and return strobes. Every clock is compared against a behavioural model.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int PSR_W  = 32;
  localparam int MODE_W = 5;
  localparam int NSRC   = 7;
  localparam int KIND_W = $clog2(NSRC);
  localparam int NBANK  = 5;
  localparam int SLOT_W = $clog2(NBANK);

  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  typedef enum logic [KIND_W-1:0] {
    K_RESET = 3'd0,
    K_DABT  = 3'd1,
    K_FIQ   = 3'd2,
    K_IRQ   = 3'd3,
    K_PABT  = 3'd4,
    K_SWI   = 3'd5,
    K_UNDEF = 3'd6
  } exc_kind_e;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  function automatic logic [MODE_W-1:0] kind_mode(exc_kind_e k);
    case (k)
      K_FIQ:           return MODE_FIQ;
      K_IRQ:           return MODE_IRQ;
      K_DABT, K_PABT:  return MODE_ABT;
      K_UNDEF:         return MODE_UND;
      default:         return MODE_SVC;
    endcase
  endfunction

  function automatic logic [7:0] kind_offset(exc_kind_e k);
    case (k)
      K_UNDEF: return 8'h04;
      K_SWI:   return 8'h08;
      K_PABT:  return 8'h0C;
      K_DABT:  return 8'h10;
      K_IRQ:   return 8'h18;
      K_FIQ:   return 8'h1C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic mode_banked(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] mode_slot(logic [MODE_W-1:0] m);
    case (m)
      MODE_IRQ: return SLOT_W'(1);
      MODE_SVC: return SLOT_W'(2);
      MODE_ABT: return SLOT_W'(3);
      MODE_UND: return SLOT_W'(4);
      default:  return SLOT_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
  import exc_pkg::*;
(
  input  logic [NSRC-1:0] req,
  input  logic            irq_mask,
  input  logic            fiq_mask,
  output logic            any,
  output exc_kind_e       kind
);
  logic [NSRC-1:0] live;

  always_comb begin
    live = req;
    live[int'(K_IRQ)] = req[int'(K_IRQ)] & ~irq_mask;
    live[int'(K_FIQ)] = req[int'(K_FIQ)] & ~fiq_mask;
    any  = |live;
    kind = K_RESET;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) kind = exc_kind_e'(KIND_W'(i));
    end
  end
endmodule

// File: rtl/exc_psr_build.sv
`timescale 1ns/1ps
module exc_psr_build
  import exc_pkg::*;
(
  input  logic [PSR_W-1:0]  old_psr,
  input  exc_kind_e         kind,
  output logic [MODE_W-1:0] new_mode,
  output logic [PSR_W-1:0]  new_psr
);
  always_comb begin
    new_mode = kind_mode(kind);
    new_psr  = old_psr;
    new_psr[MODE_W-1:0] = new_mode;
    new_psr[BIT_I] = 1'b1;
    if (kind == K_FIQ || kind == K_RESET) new_psr[BIT_F] = 1'b1;
    new_psr[BIT_T] = 1'b0;
  end
endmodule

// File: rtl/exc_spsr_bank.sv
`timescale 1ns/1ps
module exc_spsr_bank
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [PSR_W-1:0]  wr_data,
  input  logic [MODE_W-1:0] rd_mode,
  output logic              rd_hit,
  output logic [PSR_W-1:0]  rd_data
);
  logic [PSR_W-1:0] slot_q [NBANK];
  logic             wr_ok;

  assign wr_ok = wr_en && mode_banked(wr_mode);

  for (genvar g = 0; g < NBANK; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (wr_ok && mode_slot(wr_mode) == SLOT_W'(g)) slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_hit  = mode_banked(rd_mode);
    rd_data = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (rd_hit && mode_slot(rd_mode) == SLOT_W'(i)) rd_data = slot_q[i];
    end
  end

  // R4: a write to the slot being read shows on the read side next cycle
  a_r4_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_mode == wr_mode) |=>
      (rd_mode != $past(rd_mode)) || (rd_data == $past(wr_data)));
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  parameter int               PC_STEP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset,
  input  logic              req_dabt,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic              req_pabt,
  input  logic              req_swi,
  input  logic              req_undef,
  input  logic [31:0]       cur_psr,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              ent_ready,
  output logic              ent_valid,
  output logic [2:0]        ent_kind,
  output logic [4:0]        ent_mode,
  output logic [31:0]       ent_psr,
  output logic [31:0]       ent_spsr,
  output logic [ADDR_W-1:0] ent_link,
  output logic [ADDR_W-1:0] ent_vector,
  input  logic              ret_req,
  output logic              ret_valid,
  output logic [31:0]       ret_psr
);
  logic [NSRC-1:0]   req_vec;
  logic              win_any;
  exc_kind_e         win_kind;
  logic [MODE_W-1:0] nxt_mode;
  logic [PSR_W-1:0]  nxt_psr;
  logic              slot_free;
  logic              fire;
  logic              bank_hit;
  logic [PSR_W-1:0]  bank_data;

  assign req_vec = {req_undef, req_swi, req_pabt, req_irq, req_fiq, req_dabt, req_reset};

  exc_arbiter u_arb (
    .req      (req_vec),
    .irq_mask (cur_psr[BIT_I]),
    .fiq_mask (cur_psr[BIT_F]),
    .any      (win_any),
    .kind     (win_kind)
  );

  exc_psr_build u_build (
    .old_psr  (cur_psr),
    .kind     (win_kind),
    .new_mode (nxt_mode),
    .new_psr  (nxt_psr)
  );

  assign slot_free = !ent_valid || ent_ready;
  assign fire      = slot_free && win_any;

  exc_spsr_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fire),
    .wr_mode (nxt_mode),
    .wr_data (cur_psr),
    .rd_mode (cur_psr[MODE_W-1:0]),
    .rd_hit  (bank_hit),
    .rd_data (bank_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid  <= 1'b0;
      ent_kind   <= '0;
      ent_mode   <= '0;
      ent_psr    <= '0;
      ent_spsr   <= '0;
      ent_link   <= '0;
      ent_vector <= '0;
    end else if (slot_free) begin
      ent_valid <= win_any;
      if (win_any) begin
        ent_kind   <= win_kind;
        ent_mode   <= nxt_mode;
        ent_psr    <= nxt_psr;
        ent_spsr   <= cur_psr;
        ent_link   <= cur_pc + ADDR_W'(PC_STEP);
        ent_vector <= VEC_BASE + ADDR_W'(kind_offset(win_kind));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_valid <= 1'b0;
      ret_psr   <= '0;
    end else begin
      ret_valid <= ret_req;
      if (ret_req) ret_psr <= bank_hit ? bank_data : cur_psr;
    end
  end

  // R1 / R2: reset request always wins and lands in supervisor mode
  a_r1_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && req_reset) |=> ent_valid && ent_kind == 3'd0 && ent_mode == MODE_SVC);

  // R2 / R5: entry bits of the new status word
  a_r5_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> ent_psr[BIT_I] && !ent_psr[BIT_T] && ent_psr[4:0] == ent_mode);

  // R6: a lone masked normal interrupt produces no record
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && req_irq && cur_psr[BIT_I] && !req_reset && !req_dabt &&
     !(req_fiq && !cur_psr[BIT_F]) && !req_pabt && !req_swi && !req_undef) |=> !ent_valid);

  // R7: stalled record holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_ready) |=> ent_valid && $stable(ent_kind) && $stable(ent_psr) &&
      $stable(ent_spsr) && $stable(ent_link) && $stable(ent_vector));

  // R4 / R8: saved copy and link taken at the sampling edge
  a_r8_link_spsr: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ent_link == $past(cur_pc) + ADDR_W'(PC_STEP) && ent_spsr == $past(cur_psr));

  // R9: return strobe answered next cycle
  a_r9_ret_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |=> ret_valid);
endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_reset = 0, req_dabt = 0, req_fiq = 0, req_irq = 0;
  logic req_pabt = 0, req_swi = 0, req_undef = 0;
  logic [31:0] cur_psr = 32'h0000_0010;
  logic [31:0] cur_pc = 32'h0000_1000;
  logic ent_ready = 1'b1;
  logic ret_req = 1'b0;
  logic ent_valid, ret_valid;
  logic [2:0] ent_kind;
  logic [4:0] ent_mode;
  logic [31:0] ent_psr, ent_spsr, ent_link, ent_vector, ret_psr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_valid = 0;
  int          m_kind = 0;
  logic [4:0]  m_mode = '0;
  logic [31:0] m_psr = '0, m_spsr = '0, m_link = '0, m_vec = '0;
  bit          m_rvalid = 0;
  logic [31:0] m_rpsr = '0;
  logic [31:0] m_bank [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_reset(req_reset), .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq),
    .req_pabt(req_pabt), .req_swi(req_swi), .req_undef(req_undef),
    .cur_psr(cur_psr), .cur_pc(cur_pc), .ent_ready(ent_ready),
    .ent_valid(ent_valid), .ent_kind(ent_kind), .ent_mode(ent_mode),
    .ent_psr(ent_psr), .ent_spsr(ent_spsr), .ent_link(ent_link), .ent_vector(ent_vector),
    .ret_req(ret_req), .ret_valid(ret_valid), .ret_psr(ret_psr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit has_slot(logic [4:0] m);
    return m == 5'b10001 || m == 5'b10010 || m == 5'b10011 || m == 5'b10111 || m == 5'b11011;
  endfunction

  function automatic logic [4:0] mode_of(int k);
    case (k)
      2: return 5'b10001;
      3: return 5'b10010;
      1, 4: return 5'b10111;
      6: return 5'b11011;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] vec_of(int k);
    case (k)
      0: return 32'h00; 1: return 32'h10; 2: return 32'h1C; 3: return 32'h18;
      4: return 32'h0C; 5: return 32'h08; default: return 32'h04;
    endcase
  endfunction

  task automatic clear_reqs();
    {req_reset, req_dabt, req_fiq, req_irq, req_pabt, req_swi, req_undef} = '0;
  endtask

  // one clock: predict from present inputs, advance, then compare
  task automatic step();
    int order[$];
    int win;
    bit n_valid;
    logic [31:0] n_rpsr;
    bit n_rvalid;
    bit slot;
    logic [31:0] p;
    order = {};
    if (req_reset) order.push_back(0);
    if (req_dabt) order.push_back(1);
    if (req_fiq && !cur_psr[6]) order.push_back(2);
    if (req_irq && !cur_psr[7]) order.push_back(3);
    if (req_pabt) order.push_back(4);
    if (req_swi) order.push_back(5);
    if (req_undef) order.push_back(6);
    win = (order.size() > 0) ? order[0] : -1;
    n_rvalid = ret_req;
    n_rpsr = m_rpsr;
    if (ret_req) begin
      if (has_slot(cur_psr[4:0]))
        n_rpsr = m_bank.exists(int'(cur_psr[4:0])) ? m_bank[int'(cur_psr[4:0])] : 32'h0;
      else n_rpsr = cur_psr;
    end
    slot = !m_valid || ent_ready;
    n_valid = m_valid;
    if (slot) n_valid = (win >= 0);
    if (slot && win >= 0) begin
      p = cur_psr;
      p[4:0] = mode_of(win);
      p[7] = 1'b1;
      if (win == 0 || win == 2) p[6] = 1'b1;
      p[5] = 1'b0;
      m_kind = win; m_mode = mode_of(win); m_psr = p; m_spsr = cur_psr;
      m_link = cur_pc + 32'd4; m_vec = vec_of(win);
      m_bank[int'(mode_of(win))] = cur_psr;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    m_valid = n_valid; m_rvalid = n_rvalid; m_rpsr = n_rpsr;
    chk(ent_valid == m_valid, "R7 ent_valid", {31'b0, ent_valid}, {31'b0, m_valid});
    if (m_valid && ent_valid) begin
      chk(ent_kind == 3'(m_kind), "R1 kind", {29'b0, ent_kind}, 32'(m_kind));
      chk(ent_mode == m_mode, "R2 mode", {27'b0, ent_mode}, {27'b0, m_mode});
      chk(ent_vector == m_vec, "R3 vector", ent_vector, m_vec);
      chk(ent_spsr == m_spsr, "R4 saved copy", ent_spsr, m_spsr);
      chk(ent_psr == m_psr, "R5 new status", ent_psr, m_psr);
      chk(ent_link == m_link, "R8 link", ent_link, m_link);
    end
    chk(ret_valid == m_rvalid, "R9 ret_valid", {31'b0, ret_valid}, {31'b0, m_rvalid});
    if (m_rvalid) chk(ret_psr == m_rpsr, "R9 ret_psr", ret_psr, m_rpsr);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [8];
    modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111, 5'b00101};
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R10: reset state
    chk(ent_valid == 0, "R10 ent_valid in reset", {31'b0, ent_valid}, 32'h0);
    chk(ret_valid == 0, "R10 ret_valid in reset", {31'b0, ret_valid}, 32'h0);
    rst_n = 1'b1;
    step();
    // R10: slots cleared -> return in FIQ mode gives zero
    cur_psr = 32'hF000_00D1; ret_req = 1; step(); ret_req = 0;
    chk(ret_psr == 32'h0, "R10 cleared slot", ret_psr, 32'h0);

    // R1/R2/R3: each source alone, interrupts unmasked, T set (R5)
    for (int k = 0; k < 7; k++) begin
      cur_psr = 32'hA000_0030; cur_pc = 32'h0000_2000 + 32'(k * 16);
      clear_reqs();
      case (k)
        0: req_reset = 1; 1: req_dabt = 1; 2: req_fiq = 1; 3: req_irq = 1;
        4: req_pabt = 1; 5: req_swi = 1; default: req_undef = 1;
      endcase
      step(); clear_reqs(); step();
    end
    // R1: all at once, then drop reset, then swi vs undef
    cur_psr = 32'h5000_0010;
    {req_reset, req_dabt, req_fiq, req_irq, req_pabt, req_swi, req_undef} = '1;
    step(); req_reset = 0; step(); req_dabt = 0; step();
    req_fiq = 0; step(); req_irq = 0; step(); req_pabt = 0; step();
    chk(ent_kind == 3'd5, "R1 swi over undef", {29'b0, ent_kind}, 32'd5);
    clear_reqs(); step();

    // R6: masked normal interrupt alone -> nothing
    cur_psr = 32'h0000_0090; req_irq = 1; step();
    chk(ent_valid == 0, "R6 irq masked", {31'b0, ent_valid}, 32'h0);
    // R6: masked fast interrupt, lower normal interrupt wins
    cur_psr = 32'h0000_0050; req_fiq = 1; step();
    chk(ent_kind == 3'd3, "R6 fiq masked irq wins", {29'b0, ent_kind}, 32'd3);
    clear_reqs(); step();

    // R7: back-pressure hold while inputs change
    ent_ready = 0; cur_psr = 32'h3000_0010; req_swi = 1; step();
    req_swi = 0; req_dabt = 1; cur_psr = 32'hC000_0013; cur_pc = 32'h0000_9000;
    repeat (4) step();
    chk(ent_kind == 3'd5, "R7 held kind", {29'b0, ent_kind}, 32'd5);
    ent_ready = 1; step();
    chk(ent_kind == 3'd1, "R7 next after release", {29'b0, ent_kind}, 32'd1);
    clear_reqs(); step();

    // R9: return reads slot before same-edge write
    cur_psr = 32'h8000_0097; ret_req = 1; req_pabt = 1; step(); ret_req = 0; clear_reqs();
    step();
    cur_psr = 32'h0000_0097; ret_req = 1; step(); ret_req = 0;
    chk(ret_psr == 32'h8000_0097, "R9 slot after write", ret_psr, 32'h8000_0097);
    cur_psr = 32'h1234_501F; ret_req = 1; step(); ret_req = 0;
    chk(ret_psr == 32'h1234_501F, "R9 system passthrough", ret_psr, 32'h1234_501F);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cur_psr = {r[31:8], r[7:5], modes[r[2:0]]};
      cur_pc = {$urandom} & 32'hFFFF_FFFC;
      req_reset = ($urandom_range(0, 40) == 0);
      req_dabt  = ($urandom_range(0, 8) == 0);
      req_fiq   = ($urandom_range(0, 6) == 0);
      req_irq   = ($urandom_range(0, 5) == 0);
      req_pabt  = ($urandom_range(0, 8) == 0);
      req_swi   = ($urandom_range(0, 8) == 0);
      req_undef = ($urandom_range(0, 8) == 0);
      ent_ready = ($urandom_range(0, 3) != 0);
      ret_req   = ($urandom_range(0, 5) == 0);
      step();
    end
    clear_reqs(); ret_req = 0; ent_ready = 1;
    step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule